// File: doc/BRIEF.md
# Serial Nibble-Wide 64-bit Block Encryption Core

This core encrypts one 64-bit block under an 80-bit key using the well-known lightweight substitution-permutation round: round-key addition, a 4-bit S-box on every nibble, then a fixed bit permutation. Thirty-one rounds run, and a final key addition follows. The datapath holds one 64-bit state register and one 80-bit key register. The state is substituted one nibble per clock. The last nibble of each round goes through a second S-box instance that feeds the permutation network directly, so substitution of that nibble and the whole-state permutation finish together. A round therefore costs 16 cycles, not 17.

A user pulses `start` while the core is idle and presents the key as 20 nibbles on consecutive cycles, most significant first. The plaintext nibbles come in on a separate 4-bit input during the first 16 of those cycles. After the rounds, `done` pulses and the ciphertext streams out on `ct_nib`, most significant nibble first, one nibble per cycle for 16 cycles.

Top module: `p80_serial_core`

## Requirements
- R1: After reset, and after a reset applied in the middle of an encryption, `busy`, `done` and `out_valid` are low.
- R2: In the cycle where `start` is sampled while idle, key nibble 0 (key bits 79..76) and plaintext nibble 0 (bits 63..60) are taken. Key nibble k comes on the k-th following cycle for k up to 19, and plaintext nibble k on the k-th following cycle for k up to 15. Plaintext input in cycles 16..19 of loading is ignored.
- R3: The ciphertext equals the 31-round encryption. It uses the S-box 0..F -> C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 and moves state bit i to bit 16*i mod 63 (bit 63 stays). Each round adds key bits 79..16 before substitution, and the final addition uses the 32nd round key. Known answers include key 0 and plaintext 0 giving 5579C1387B228445.
- R4: Each round takes 16 cycles. `done` is high after the 516th rising edge, counting from and including the edge that samples `start`.
- R5: `done` is high for exactly one cycle. `out_valid` is high for 16 cycles starting in that same cycle. In output cycle j, `ct_nib` carries ciphertext bits 63-4j..60-4j.
- R6: `busy` is high from the cycle after `start` until the last output cycle. `start` is ignored while `busy` is high: the latency and ciphertext of the running job are unchanged, and no new job follows.
- R7: The key register changes only during loading and on the last cycle of a round. There it is rotated left by 61, its top nibble is passed through the S-box, and the 5-bit round number (1..31) is XORed into bits 19..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a job when idle; carries nibble 0 in the same cycle |
| key_nib | input | 4 | Serial key nibble, most significant first |
| pt_nib | input | 4 | Serial plaintext nibble, most significant first |
| busy | output | 1 | Job in progress (loading, rounds or output) |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| out_valid | output | 1 | `ct_nib` carries a ciphertext nibble |
| ct_nib | output | 4 | Serial ciphertext nibble, most significant first |

## Verification
Three things share the last cycle of every round: substitution of the last nibble, the whole-state permutation, and the key-schedule step. In round 31 the final key addition joins them. Any vector whose ciphertext depends on all 64 state bits exercises that merged cycle. The bench runs four known-answer pairs that cover all-zero and all-one keys and blocks. It judges the merged cycle by exact ciphertext match together with `done` arriving on exactly the 516th edge. One cycle too many or one misplaced nibble breaks both checks.

// File: rtl/p80_pkg.sv
package p80_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LOAD,
      PH_ROUND,
      PH_UNLOAD
   } phase_e;

   // 4-bit substitution table of the round function
   function automatic logic [3:0] sbox4(input logic [3:0] x);
      logic [3:0] y;
      case (x)
         4'h0: y = 4'hC;
         4'h1: y = 4'h5;
         4'h2: y = 4'h6;
         4'h3: y = 4'hB;
         4'h4: y = 4'h9;
         4'h5: y = 4'h0;
         4'h6: y = 4'hA;
         4'h7: y = 4'hD;
         4'h8: y = 4'h3;
         4'h9: y = 4'hE;
         4'hA: y = 4'hF;
         4'hB: y = 4'h8;
         4'hC: y = 4'h4;
         4'hD: y = 4'h7;
         4'hE: y = 4'h1;
         default: y = 4'h2;
      endcase
      return y;
   endfunction

endpackage

// File: rtl/p80_sbox.sv
module p80_sbox (
   input  logic [3:0] x,
   output logic [3:0] y
);
   assign y = p80_pkg::sbox4(x);
endmodule

// File: rtl/p80_perm.sv
module p80_perm #(
   parameter int BLOCK_W = 64
) (
   input  logic [BLOCK_W-1:0] d,
   output logic [BLOCK_W-1:0] q
);
   localparam int STRIDE = BLOCK_W / 4;

   for (genvar i = 0; i < BLOCK_W; i++) begin : g_bit
      localparam int DST = (i == BLOCK_W-1) ? i : (i * STRIDE) % (BLOCK_W-1);
      assign q[DST] = d[i];
   end
endmodule

// File: rtl/p80_keysched.sv
module p80_keysched #(
   parameter int KEY_W   = 80,
   parameter int BLOCK_W = 64,
   parameter int NIB     = 4,
   parameter int ROT     = 61,
   parameter int RND_W   = 5,
   parameter int CTR_LO  = 15,
   parameter int SLOT_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic [NIB-1:0]     nib_in,
   input  logic               upd_en,
   input  logic [RND_W-1:0]   rnd,
   input  logic [SLOT_W-1:0]  slot,
   output logic [NIB-1:0]     rk_nib,
   output logic [BLOCK_W-1:0] next_rk,
   output logic [KEY_W-1:0]   key_q
);
   logic [KEY_W-1:0] rotated;
   logic [KEY_W-1:0] key_next;
   logic [NIB-1:0]   top_sub;

   assign rotated = {key_q[KEY_W-ROT-1:0], key_q[KEY_W-1:KEY_W-ROT]};

   p80_sbox u_ks_sbox (.x(rotated[KEY_W-1 -: NIB]), .y(top_sub));

   always_comb begin
      key_next = rotated;
      key_next[KEY_W-1 -: NIB] = top_sub;
      key_next[CTR_LO +: RND_W] = rotated[CTR_LO +: RND_W] ^ rnd;
   end

   assign next_rk = key_next[KEY_W-1 -: BLOCK_W];
   assign rk_nib  = key_q[KEY_W-1-NIB*int'(slot) -: NIB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        key_q <= '0;
      else if (shift_en) key_q <= {key_q[KEY_W-NIB-1:0], nib_in};
      else if (upd_en)   key_q <= key_next;
   end
endmodule

// File: rtl/p80_ctrl.sv
module p80_ctrl #(
   parameter int LOAD_CYC = 20,
   parameter int NIBS     = 16,
   parameter int ROUNDS   = 31,
   parameter int RND_W    = 5,
   parameter int CNT_W    = 5,
   parameter int SLOT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              key_shift,
   output logic              pt_shift,
   output logic              sub_step,
   output logic              round_end,
   output logic              last_round,
   output logic              out_shift,
   output logic [RND_W-1:0]  rnd,
   output logic [SLOT_W-1:0] slot,
   output logic              busy,
   output logic              done,
   output logic              out_valid
);
   import p80_pkg::*;

   localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_CYC-1);
   localparam logic [CNT_W-1:0] NIB_LAST  = CNT_W'(NIBS-1);
   localparam logic [CNT_W-1:0] NIB_CNT   = CNT_W'(NIBS);
   localparam logic [RND_W-1:0] RND_LAST  = RND_W'(ROUNDS);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;

   wire idle_go = (phase_q == PH_IDLE) && start;

   assign key_shift  = idle_go || (phase_q == PH_LOAD);
   assign pt_shift   = idle_go || ((phase_q == PH_LOAD) && (cnt_q < NIB_CNT));
   assign sub_step   = (phase_q == PH_ROUND) && (cnt_q != NIB_LAST);
   assign round_end  = (phase_q == PH_ROUND) && (cnt_q == NIB_LAST);
   assign last_round = round_end && (rnd == RND_LAST);
   assign out_shift  = (phase_q == PH_UNLOAD);
   assign out_valid  = (phase_q == PH_UNLOAD);
   assign busy       = (phase_q != PH_IDLE);
   assign slot       = cnt_q[SLOT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         rnd     <= RND_W'(1);
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase_q)
            PH_IDLE: if (start) begin
               phase_q <= PH_LOAD;
               cnt_q   <= CNT_W'(1);
            end
            PH_LOAD: if (cnt_q == LOAD_LAST) begin
               phase_q <= PH_ROUND;
               cnt_q   <= '0;
               rnd     <= RND_W'(1);
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            PH_ROUND: if (cnt_q == NIB_LAST) begin
               cnt_q <= '0;
               if (rnd == RND_LAST) begin
                  phase_q <= PH_UNLOAD;
                  done    <= 1'b1;
               end else begin
                  rnd <= rnd + 1'b1;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            default: if (cnt_q == NIB_LAST) begin
               phase_q <= PH_IDLE;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/p80_serial_core.sv
module p80_serial_core #(
   parameter int BLOCK_W = 64,
   parameter int KEY_W   = 80,
   parameter int NIB     = 4,
   parameter int ROUNDS  = 31
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [NIB-1:0] key_nib,
   input  logic [NIB-1:0] pt_nib,
   output logic           busy,
   output logic           done,
   output logic           out_valid,
   output logic [NIB-1:0] ct_nib
);
   localparam int NIBS     = BLOCK_W / NIB;
   localparam int LOAD_CYC = KEY_W / NIB;
   localparam int RND_W    = $clog2(ROUNDS + 1);
   localparam int CNT_W    = $clog2(LOAD_CYC + 1);
   localparam int SLOT_W   = $clog2(NIBS);

   if (BLOCK_W != 64 || KEY_W != 80 || NIB != 4) begin : g_bad_geom
      $error("p80_serial_core: round function fixed at 64-bit block, 80-bit key, 4-bit slices");
   end
   if (ROUNDS < 1 || ROUNDS > 31) begin : g_bad_rounds
      $error("p80_serial_core: ROUNDS must fit the 5-bit round counter");
   end

   logic               key_shift, pt_shift, sub_step, round_end, last_round, out_shift;
   logic [RND_W-1:0]   rnd;
   logic [SLOT_W-1:0]  slot;
   logic [NIB-1:0]     rk_nib;
   logic [BLOCK_W-1:0] next_rk;
   logic [KEY_W-1:0]   key_q;
   logic [BLOCK_W-1:0] state_q;
   logic [NIB-1:0]     mixed, sub_serial, sub_last;
   logic [BLOCK_W-1:0] pre_perm, post_perm;

   p80_ctrl #(
      .LOAD_CYC(LOAD_CYC), .NIBS(NIBS), .ROUNDS(ROUNDS),
      .RND_W(RND_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .key_shift(key_shift), .pt_shift(pt_shift), .sub_step(sub_step),
      .round_end(round_end), .last_round(last_round), .out_shift(out_shift),
      .rnd(rnd), .slot(slot), .busy(busy), .done(done), .out_valid(out_valid)
   );

   p80_keysched #(
      .KEY_W(KEY_W), .BLOCK_W(BLOCK_W), .NIB(NIB), .ROT(61),
      .RND_W(RND_W), .CTR_LO(15), .SLOT_W(SLOT_W)
   ) u_ks (
      .clk(clk), .rst_n(rst_n), .shift_en(key_shift), .nib_in(key_nib),
      .upd_en(round_end), .rnd(rnd), .slot(slot),
      .rk_nib(rk_nib), .next_rk(next_rk), .key_q(key_q)
   );

   assign mixed = state_q[BLOCK_W-1 -: NIB] ^ rk_nib;

   // serial-path S-box and permutation-feeding S-box, kept separate
   p80_sbox u_sbox_serial (.x(mixed), .y(sub_serial));
   p80_sbox u_sbox_last   (.x(mixed), .y(sub_last));

   assign pre_perm = {state_q[BLOCK_W-NIB-1:0], sub_last};

   p80_perm #(.BLOCK_W(BLOCK_W)) u_perm (.d(pre_perm), .q(post_perm));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= '0;
      else if (pt_shift)
         state_q <= {state_q[BLOCK_W-NIB-1:0], pt_nib};
      else if (sub_step)
         state_q <= {state_q[BLOCK_W-NIB-1:0], sub_serial};
      else if (round_end)
         state_q <= last_round ? (post_perm ^ next_rk) : post_perm;
      else if (out_shift)
         state_q <= {state_q[BLOCK_W-NIB-1:0], {NIB{1'b0}}};
   end

   assign ct_nib = state_q[BLOCK_W-1 -: NIB];
endmodule

// File: rtl/p80_core_chk.sv
module p80_core_chk #(
   parameter int KEY_W = 80
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             out_valid,
   input logic             sub_step,
   input logic             round_end,
   input logic [KEY_W-1:0] key_q
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                   // R5
   AST_DONE_OPENS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> out_valid);                               // R5
   AST_DONE_FOLLOWS_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(round_end));                 // R4
   AST_KEY_HELD_MIDROUND: assert property (@(posedge clk) disable iff (!rst_n)
      sub_step |=> $stable(key_q));                      // R7
   AST_OUTPUT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy);                               // R6
   AST_JOB_NOT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !out_valid) |=> busy);                    // R6
endmodule

bind p80_serial_core p80_core_chk #(.KEY_W(KEY_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .out_valid(out_valid),
   .sub_step(sub_step), .round_end(round_end), .key_q(key_q)
);

// File: tb/p80_serial_core_tb.sv
`timescale 1ns/1ps
module p80_serial_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] key_nib = '0;
   logic [3:0] pt_nib = '0;
   logic       busy, done, out_valid;
   logic [3:0] ct_nib;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   p80_serial_core dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .key_nib(key_nib), .pt_nib(pt_nib),
      .busy(busy), .done(done), .out_valid(out_valid), .ct_nib(ct_nib)
   );

   // {key[79:0], plaintext[63:0], ciphertext[63:0]}
   localparam int NV = 4;
   localparam logic [207:0] VEC [NV] = '{
      {80'h0, 64'h0, 64'h5579C1387B228445},
      {80'hFFFFFFFFFFFFFFFFFFFF, 64'h0, 64'hE72C46C0F5945049},
      {80'h0, 64'hFFFFFFFFFFFFFFFF, 64'hA112FFC72F68417B},
      {80'hFFFFFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h3333DCD3213210D2}
   };

   task automatic check(input bit ok, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic run_job(input logic [79:0] k, input logic [63:0] p,
                          input logic [63:0] exp, input bit poke);
      int lat;
      int vcnt;
      logic [63:0] ct;
      @(negedge clk);
      start = 1'b1;
      key_nib = k[79:76];
      pt_nib = p[63:60];
      lat = 0;
      while (1) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         start = 1'b0;
         if (lat == 1) check(busy, "R6 busy after start", 64'(busy), 64'd1);
         if (lat < 20) begin
            key_nib = k[79-4*lat -: 4];
            pt_nib = (lat < 16) ? p[63-4*lat -: 4] : 4'h9; // R2: tail ignored
         end else if (poke && lat == 100) begin
            start = 1'b1;                                   // R6: ignored
            key_nib = 4'hA;
            pt_nib = 4'h5;
         end
         if (done || lat >= 1000) break;
      end
      check(lat == 516, "R4 latency to done", 64'(lat), 64'd516);
      ct = '0;
      vcnt = 0;
      for (int j = 0; j < 16; j++) begin
         if (out_valid) vcnt++;
         if (j == 1) check(!done, "R5 done width", 64'(done), 64'd0);
         ct = {ct[59:0], ct_nib};
         if (poke && j == 5) start = 1'b1;                 // R6: ignored
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
      end
      check(vcnt == 16, "R5 out_valid length", 64'(vcnt), 64'd16);
      check(ct == exp, "R3 R2 ciphertext", ct, exp);
      check(!out_valid, "R5 out_valid ends", 64'(out_valid), 64'd0);
      check(!busy, "R6 idle after output", 64'(busy), 64'd0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(!busy && !done && !out_valid, "R1 reset outputs",
            {61'd0, busy, done, out_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !out_valid, "R1 idle after release",
            {61'd0, busy, done, out_valid}, 64'd0);

      // known-answer walk; R7 key schedule is covered through every answer
      for (int v = 0; v < NV; v++)
         run_job(VEC[v][207:128], VEC[v][127:64], VEC[v][63:0], v == 2);

      // R1: reset in the middle of a job
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (60) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(!busy && !done && !out_valid, "R1 mid-job reset",
            {61'd0, busy, done, out_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // recovery with start pokes during rounds and output (R6)
      run_job(VEC[0][207:128], VEC[0][127:64], VEC[0][63:0], 1'b1);
      run_job(VEC[3][207:128], VEC[3][127:64], VEC[3][63:0], 1'b0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule